// File: doc/BRIEF.md
# Four-Channel Hit Zero Suppressor with Time Markers

This block sits between a group of time-to-digital channels and a narrow pipeline buffer. A free-running phase counter starts at zero on a synchronous clear. Every time its two low bits are zero, the block copies the hit flag, the coarse time and the fine time of all four channels into a hold-shift register. The register then presents one channel per cycle, channel 0 first. Only a channel that holds a hit produces a buffer write. An empty channel costs a cycle but writes nothing, so a channel cannot record two hits less than four cycles apart.

Whenever the full phase counter is zero, the block writes a time marker word instead. The marker carries an epoch count of elapsed 16-cycle periods, so the reader can rebuild absolute time from the 4 coarse bits stored in each hit. If a marker and a hit become due together, the marker goes first and the hit waits one slot in a single-entry skid register. Every output write is a registered one-cycle strobe that comes with a 9-bit word.

Top module: `chgrp_zero_supp`

## Requirements
- R1: After a cycle with `sclr` high, the inputs present in the first cycle after the clear are loaded. Reloads follow every 4 cycles. Counting the clear edge as cycle 0, channel c of the load taken in cycle 4m appears on the outputs in cycle 4m+2+c, provided no marker gets in the way. Cycle 0 itself shows no write.
- R2: A hit word is `{1'b1, ch[1:0], coarse[3:0], fine[1:0]}`, with bit 8 the highest. Channel c uses `hit_coarse[4c+3:4c]` and `hit_fine[2c+1:2c]`.
- R3: A channel whose `hit_vld` bit is 0 at load time produces no write in its slot.
- R4: A marker word `{3'b000, epoch[5:0]}` appears in cycle 16n+1. Its epoch is n mod 64, and it restarts at 0 after a clear.
- R5: Input values in cycles that are not load cycles have no effect on any output word.
- R6: When a marker and a hit fall due in the same cycle, the marker is written first. The hit follows one cycle later, and a hit from the next slot slides back by one cycle behind it.
- R7: If the skid register is still holding a word when the next marker is due and the current slot also holds a hit, that current-slot hit is discarded. The held word is written in the cycle after the marker.
- R8: `push_o` is high for exactly one cycle per written word. `word_o` is all zeros in every cycle where `push_o` is low.
- R9: While `rst_n` is low, `push_o` is 0 and `word_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclr | input | 1 | Synchronous clear of phase, epoch, hold register and skid |
| hit_vld | input | 4 | Per-channel hit flag, bit c for channel c |
| hit_coarse | input | 16 | Per-channel coarse time, 4 bits per channel |
| hit_fine | input | 8 | Per-channel fine time, 2 bits per channel |
| push_o | output | 1 | One-cycle buffer write strobe |
| word_o | output | 9 | Word to write, zero when no strobe |

## Verification
The marker insertion and the channel-3 slot land on the same cycle whenever a load's last channel reaches a phase of zero. The bench provokes this by loading only channel 3 in the load taken in cycle 12, and only channel 0 in the load taken in cycle 16. It then checks that the marker, the delayed channel-3 hit and the channel-0 hit each appear exactly one cycle after the previous one. A continuous flood on all channels keeps the skid register full up to the next marker. The bench judges that case by the exact words around cycle 33: the lost hit must be absent, and its neighbours must be present in order.

// File: rtl/zs_pkg.sv
package zs_pkg;

  // Which source wins the output slot in a given cycle.
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_MARK = 2'd1,
    PICK_SKID = 2'd2,
    PICK_HEAD = 2'd3
  } pick_e;

endpackage

// File: rtl/zs_phase_ctr.sv
module zs_phase_ctr #(
  parameter int PH_W    = 4,
  parameter int LANE_W  = 2,
  parameter int EPOCH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclr,
  output logic               load_en,
  output logic               mark_due,
  output logic [EPOCH_W-1:0] epoch
);

  logic [PH_W-1:0]    ph_q;
  logic [EPOCH_W-1:0] epoch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      epoch_q <= '0;
    end else if (sclr) begin
      ph_q    <= '0;
      epoch_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
      if (ph_q == {PH_W{1'b1}}) epoch_q <= epoch_q + 1'b1;
    end
  end

  // Lane bits at zero: take a fresh snapshot of all channels.
  assign load_en  = !sclr && (ph_q[LANE_W-1:0] == '0);
  // Whole phase at zero: a time marker is owed.
  assign mark_due = !sclr && (ph_q == '0);
  assign epoch    = epoch_q;

endmodule

// File: rtl/zs_hold_shift.sv
module zs_hold_shift #(
  parameter int N_CH     = 4,
  parameter int CH_W     = 2,
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclr,
  input  logic                       load_en,
  input  logic [N_CH-1:0]            hit_vld,
  input  logic [N_CH*COARSE_W-1:0]   hit_coarse,
  input  logic [N_CH*FINE_W-1:0]     hit_fine,
  output logic                       head_v,
  output logic [CH_W-1:0]            head_ch,
  output logic [COARSE_W-1:0]        head_coarse,
  output logic [FINE_W-1:0]          head_fine
);

  localparam int SLOT_W = 1 + CH_W + COARSE_W + FINE_W;

  logic [SLOT_W-1:0] slot_q [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_slot
    logic [SLOT_W-1:0] snap;
    assign snap = {hit_vld[i], CH_W'(i),
                   hit_coarse[i*COARSE_W +: COARSE_W],
                   hit_fine[i*FINE_W +: FINE_W]};

    if (i == N_CH - 1) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q[i] <= '0;
        else if (sclr)    slot_q[i] <= '0;
        else if (load_en) slot_q[i] <= snap;
        else              slot_q[i] <= '0;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       slot_q[i] <= '0;
        else if (sclr)    slot_q[i] <= '0;
        else if (load_en) slot_q[i] <= snap;
        else              slot_q[i] <= slot_q[i+1];
      end
    end
  end

  assign {head_v, head_ch, head_coarse, head_fine} = slot_q[0];

endmodule

// File: rtl/zs_push_arb.sv
module zs_push_arb
  import zs_pkg::*;
#(
  parameter int WORD_W   = 9,
  parameter int CH_W     = 2,
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 2,
  parameter int EPOCH_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclr,
  input  logic                mark_due,
  input  logic [EPOCH_W-1:0]  epoch,
  input  logic                head_v,
  input  logic [CH_W-1:0]     head_ch,
  input  logic [COARSE_W-1:0] head_coarse,
  input  logic [FINE_W-1:0]   head_fine,
  output logic                skid_v,
  output logic                drop_ev,
  output logic                push_o,
  output logic [WORD_W-1:0]   word_o
);

  localparam int PAD_W = WORD_W - EPOCH_W;

  function automatic logic [WORD_W-1:0] enc_hit(
    input logic [CH_W-1:0] ch, input logic [COARSE_W-1:0] c,
    input logic [FINE_W-1:0] f);
    return {1'b1, ch, c, f};
  endfunction

  function automatic logic [WORD_W-1:0] enc_mark(input logic [EPOCH_W-1:0] e);
    return {{PAD_W{1'b0}}, e};
  endfunction

  logic [WORD_W-1:0] head_word, skid_q;
  logic              skid_vq;
  pick_e             pick;

  assign head_word = enc_hit(head_ch, head_coarse, head_fine);

  always_comb begin
    if (mark_due)     pick = PICK_MARK;
    else if (skid_vq) pick = PICK_SKID;
    else if (head_v)  pick = PICK_HEAD;
    else              pick = PICK_NONE;
  end

  assign drop_ev = mark_due && skid_vq && head_v;
  assign skid_v  = skid_vq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skid_vq <= 1'b0;
      skid_q  <= '0;
    end else if (sclr) begin
      skid_vq <= 1'b0;
      skid_q  <= '0;
    end else begin
      unique case (pick)
        PICK_MARK: if (!skid_vq && head_v) begin
          skid_vq <= 1'b1;
          skid_q  <= head_word;
        end
        PICK_SKID: begin
          skid_vq <= head_v;
          skid_q  <= head_v ? head_word : '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_o <= 1'b0;
      word_o <= '0;
    end else if (sclr) begin
      push_o <= 1'b0;
      word_o <= '0;
    end else begin
      push_o <= (pick != PICK_NONE);
      unique case (pick)
        PICK_MARK: word_o <= enc_mark(epoch);
        PICK_SKID: word_o <= skid_q;
        PICK_HEAD: word_o <= head_word;
        default:   word_o <= '0;
      endcase
    end
  end

endmodule

// File: rtl/chgrp_zero_supp.sv
module chgrp_zero_supp #(
  parameter int N_CH     = 4,
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 2,
  parameter int PH_W     = 4,
  localparam int CH_W    = $clog2(N_CH),
  localparam int WORD_W  = 1 + CH_W + COARSE_W + FINE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sclr,
  input  logic [N_CH-1:0]          hit_vld,
  input  logic [N_CH*COARSE_W-1:0] hit_coarse,
  input  logic [N_CH*FINE_W-1:0]   hit_fine,
  output logic                     push_o,
  output logic [WORD_W-1:0]        word_o
);

  localparam int EPOCH_W = WORD_W - 3;

  // Named internal events, observed by the bound checker.
  logic                load_en, mark_due;
  logic [EPOCH_W-1:0]  epoch;
  logic                head_v, skid_v, drop_ev;
  logic [CH_W-1:0]     head_ch;
  logic [COARSE_W-1:0] head_coarse;
  logic [FINE_W-1:0]   head_fine;

  zs_phase_ctr #(.PH_W(PH_W), .LANE_W(CH_W), .EPOCH_W(EPOCH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .sclr(sclr),
    .load_en(load_en), .mark_due(mark_due), .epoch(epoch)
  );

  zs_hold_shift #(.N_CH(N_CH), .CH_W(CH_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .load_en(load_en),
    .hit_vld(hit_vld), .hit_coarse(hit_coarse), .hit_fine(hit_fine),
    .head_v(head_v), .head_ch(head_ch), .head_coarse(head_coarse), .head_fine(head_fine)
  );

  zs_push_arb #(.WORD_W(WORD_W), .CH_W(CH_W), .COARSE_W(COARSE_W),
                .FINE_W(FINE_W), .EPOCH_W(EPOCH_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .sclr(sclr),
    .mark_due(mark_due), .epoch(epoch),
    .head_v(head_v), .head_ch(head_ch), .head_coarse(head_coarse), .head_fine(head_fine),
    .skid_v(skid_v), .drop_ev(drop_ev), .push_o(push_o), .word_o(word_o)
  );

endmodule

// File: rtl/zs_checker.sv
module zs_checker #(
  parameter int WORD_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclr,
  input logic              push_o,
  input logic [WORD_W-1:0] word_o,
  input logic              mark_due,
  input logic              head_v,
  input logic              skid_v,
  input logic              drop_ev
);

  a_r4_marker_emitted: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    mark_due |=> push_o && (word_o[WORD_W-1 -: 3] == 3'b000));

  a_r6_skid_drains: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    skid_v && !mark_due |=> push_o && word_o[WORD_W-1]);

  a_r2_head_direct: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    head_v && !mark_due && !skid_v |=> push_o && word_o[WORD_W-1]);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    !mark_due && !skid_v && !head_v |=> !push_o);

  a_r7_drop_keeps_skid: assert property (@(posedge clk) disable iff (!rst_n || sclr)
    drop_ev |=> skid_v);

  a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !push_o |-> (word_o == '0));

endmodule

bind chgrp_zero_supp zs_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclr(sclr), .push_o(push_o), .word_o(word_o),
  .mark_due(mark_due), .head_v(head_v), .skid_v(skid_v), .drop_ev(drop_ev)
);

// File: tb/chgrp_zero_supp_test.sv
module chgrp_zero_supp_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, sclr;
  logic [3:0]  vld;
  logic [15:0] crs;
  logic [7:0]  fin;
  logic        push;
  logic [8:0]  word;

  int total = 0;
  int bad   = 0;

  logic       lp [0:63];
  logic [8:0] lw [0:63];

  // Row: {hit flags[3:0], coarse ch3..ch0, fine ch3..ch0}; rows 3, 7, 11 keep ch3 empty.
  localparam logic [27:0] TBL [12] = '{
    {4'b0001, 16'h4321, 8'hE4}, {4'b1111, 16'h89AB, 8'h1B},
    {4'b0000, 16'hFFFF, 8'hFF}, {4'b0111, 16'h0C5D, 8'h36},
    {4'b1010, 16'hF0E1, 8'h9C}, {4'b0101, 16'h7777, 8'h55},
    {4'b1000, 16'h2000, 8'hC0}, {4'b0011, 16'hDEAD, 8'h0F},
    {4'b1100, 16'hBEEF, 8'hA5}, {4'b0110, 16'h1234, 8'h5A},
    {4'b1001, 16'hCAFE, 8'h33}, {4'b0100, 16'h0F0F, 8'hCC}
  };

  chgrp_zero_supp uut (
    .clk(clk), .rst_n(rst_n), .sclr(sclr),
    .hit_vld(vld), .hit_coarse(crs), .hit_fine(fin),
    .push_o(push), .word_o(word)
  );

  function automatic logic [8:0] exp_hit(input int ch, input int c, input int f);
    return 9'(256 + ch * 64 + c * 4 + f);
  endfunction

  function automatic logic [8:0] exp_mark(input int ep);
    return 9'(ep % 64);
  endfunction

  task automatic check_slot(input int k, input bit ep, input logic [8:0] ew, input string req);
    total++;
    if (lp[k] !== ep || lw[k] !== ew) begin
      bad++;
      $display("FAIL %s cycle %0d actual push=%0b word=%h expected push=%0b word=%h",
               req, k, lp[k], lw[k], ep, ew);
    end
  endtask

  task automatic clear_seq();
    @(negedge clk) sclr = 1'b1;
    @(negedge clk) sclr = 1'b0;
  endtask

  // mode 0: table walk, 1: marker collision, 2: continuous flood
  task automatic run(input int ncyc, input int mode);
    for (int k = 0; k < ncyc; k++) begin
      case (mode)
        0: if (k % 4 == 0 && k / 4 < 12) {vld, crs, fin} = TBL[k / 4];
           else begin vld = 4'hF; crs = 16'hFFFF ^ 16'(k); fin = 8'hFF; end
        1: begin
          {vld, crs, fin} = '0;
          if (k == 12) begin vld = 4'b1000; crs = 16'hA000; fin = 8'b10_00_00_00; end
          if (k == 16) begin vld = 4'b0001; crs = 16'h0005; fin = 8'b00_00_00_01; end
        end
        default: begin
          vld = 4'hF; crs = {4{4'((k / 4) % 16)}}; fin = 8'b11_10_01_00;
        end
      endcase
      lp[k] = push;
      lw[k] = word;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclr = 1'b0; vld = '0; crs = '0; fin = '0;
    repeat (3) @(negedge clk);
    total++;
    if (push !== 1'b0 || word !== 9'd0) begin
      bad++;
      $display("FAIL R9 reset actual push=%0b word=%h expected push=0 word=000", push, word);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 order, R2 encoding, R3 empty slots, R4 markers, R5 garbage between loads
    clear_seq();
    run(50, 0);
    check_slot(0, 1'b0, 9'd0, "R1 no write on clear cycle");
    check_slot(1, 1'b1, exp_mark(0), "R4 first marker");
    for (int m = 0; m < 12; m++) begin
      for (int c = 0; c < 4; c++) begin
        int v;
        v = 4 * m + 2 + c;
        if (m % 4 == 3 && c == 3)
          check_slot(v, 1'b1, exp_mark((m + 1) / 4), "R4 marker epoch");
        else if (TBL[m][24 + c])
          check_slot(v, 1'b1, exp_hit(c, int'(TBL[m][8 + 4 * c +: 4]), int'(TBL[m][2 * c +: 2])),
                     "R1 R2 R5 hit slot");
        else
          check_slot(v, 1'b0, 9'd0, "R3 R8 empty slot");
      end
    end

    // Marker and channel-3 hit due together
    clear_seq();
    run(24, 1);
    check_slot(17, 1'b1, exp_mark(1), "R6 marker first");
    check_slot(18, 1'b1, exp_hit(3, 10, 2), "R6 delayed ch3 hit");
    check_slot(19, 1'b1, exp_hit(0, 5, 1), "R6 slid ch0 hit");
    check_slot(20, 1'b0, 9'd0, "R6 R8 quiet after slide");

    // Flood: skid still full at next marker
    clear_seq();
    run(37, 2);
    check_slot(2, 1'b1, exp_hit(0, 0, 0), "R1 flood first hit");
    begin
      int holes;
      holes = 0;
      for (int k = 1; k < 36; k++) if (lp[k] !== 1'b1) holes++;
      total++;
      if (holes != 0) begin
        bad++;
        $display("FAIL R8 flood idle cycles actual=%0d expected=0", holes);
      end
    end
    check_slot(32, 1'b1, exp_hit(1, 7, 1), "R7 before marker");
    check_slot(33, 1'b1, exp_mark(2), "R7 marker");
    check_slot(34, 1'b1, exp_hit(2, 7, 2), "R7 held word after marker");
    check_slot(35, 1'b1, exp_hit(0, 8, 0), "R7 ch3 dropped");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule